// File: doc/BRIEF.md
# Mode-Aware Instruction Pointer Register

This block keeps a processor's instruction pointer as a 48-bit signed quantity and updates it according to the active processor mode and the default operand-size bit of the current code segment. A write strobe and a write value come in together with a three-bit mode code and that size bit. The block decides whether the write replaces the whole pointer, stores a 32-bit value and clears the bits above it, or swaps in only the low 16 bits and keeps everything above. In modes that have no instruction pointer update path, writes are ignored.

Two outputs are provided. One is the raw stored pointer. The other is a 64-bit view sized to the current mode:

- the sign-extended pointer in 64-bit mode,
- a zero-extended 32-bit pointer, or
- a zero-extended 16-bit pointer.

Fetch logic and debug paths read the view. State save paths read the raw pointer.

Top module: `ip_reg_mode`

## Requirements
- R1: A synchronous active-high reset loads the stored pointer with the parameter RESET_VEC (default zero) at the next rising clock edge.
- R2: While the write strobe is low at a rising edge, the stored pointer keeps its value.
- R3: With mode code 0 (64-bit mode) and the strobe high, all 48 bits of the write value become the stored pointer at the next edge.
- R4: With mode code 1 and the code-segment size bit at 1, bits 31:0 of the write value are stored and pointer bits 47:32 become zero. This also holds right after a 16-bit write.
- R5: With mode code 1 and the size bit at 0, only pointer bits 15:0 take bits 15:0 of the write value; bits 47:16 keep their previous contents.
- R6: Every mode code other than 0 and 1 (codes 2 to 7) leaves the pointer unchanged when the strobe is high.
- R7: In any mode code other than 1, the 64-bit view equals the stored pointer with bit 47 copied into view bits 63:48.
- R8: In mode code 1 with the size bit at 1, the view is pointer bits 31:0 with view bits 63:32 zero.
- R9: In mode code 1 with the size bit at 0, the view is pointer bits 15:0 with view bits 63:16 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_code | input | 3 | Processor mode: 0 is 64-bit mode, 1 is 32-bit mode, 2 to 7 take no writes |
| cs_d | input | 1 | Code-segment default size bit: 1 selects 32-bit, 0 selects 16-bit (used only in mode 1) |
| wr_en | input | 1 | Write strobe |
| wr_value | input | 48 | New pointer value |
| ip_full | output | 48 | Stored pointer |
| ip_view | output | 64 | Mode-sized view of the pointer |

## Verification
The write-path properties assume that mode_code, cs_d, wr_en and wr_value are stable around each rising edge. They also assume that the mode and size bit in force at an edge are the ones that govern that write. The bench changes all inputs only on falling edges, so each write sees a single consistent mode and size bit. The view properties are checked against the mode in force at the sampling edge. The stimulus holds the mode after a write so that each view is sampled under the mode that produced it. The write values carry set bits in every region (bit 47, bits 47:32, bits 31:16) so that clearing, keeping and sign extension can each be told apart.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

   localparam int unsigned MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_LONG   = 3'd0;
   localparam logic [MODE_W-1:0] MODE_COMPAT = 3'd1;

   // How a write is applied to the stored pointer
   typedef enum logic [1:0] {
      WS_IGNORE = 2'd0,
      WS_FULL   = 2'd1,
      WS_WIDE   = 2'd2,
      WS_SHORT  = 2'd3
   } ipr_wsize_e;

endpackage

// File: rtl/ipr_size_decode.sv
module ipr_size_decode
   import ipr_pkg::*;
(
   input  logic [MODE_W-1:0] mode_code,
   input  logic              cs_d,
   output ipr_wsize_e        wsize
);

   always_comb begin
      if (mode_code == MODE_LONG) begin
         wsize = WS_FULL;
      end else if (mode_code == MODE_COMPAT) begin
         wsize = cs_d ? WS_WIDE : WS_SHORT;
      end else begin
         wsize = WS_IGNORE;
      end
   end

endmodule

// File: rtl/ipr_write_merge.sv
module ipr_write_merge
   import ipr_pkg::*;
#(
   parameter int unsigned PTR_W   = 48,
   parameter int unsigned WIDE_W  = 32,
   parameter int unsigned SHORT_W = 16
) (
   input  logic [PTR_W-1:0] ip_cur,
   input  logic [PTR_W-1:0] wr_value,
   input  ipr_wsize_e       wsize,
   output logic [PTR_W-1:0] ip_next
);

   localparam int unsigned WIDE_HI  = PTR_W - WIDE_W;
   localparam int unsigned SHORT_HI = PTR_W - SHORT_W;
   localparam logic [PTR_W-1:0] WIDE_MASK  = {{WIDE_HI{1'b0}}, {WIDE_W{1'b1}}};
   localparam logic [PTR_W-1:0] SHORT_MASK = {{SHORT_HI{1'b0}}, {SHORT_W{1'b1}}};

   if (!(SHORT_W < WIDE_W && WIDE_W < PTR_W)) begin : g_bad_widths
      $error("ipr_write_merge: need SHORT_W < WIDE_W < PTR_W");
   end

   always_comb begin
      unique case (wsize)
         WS_FULL:  ip_next = wr_value;
         WS_WIDE:  ip_next = wr_value & WIDE_MASK;
         WS_SHORT: ip_next = (ip_cur & ~SHORT_MASK) | (wr_value & SHORT_MASK);
         default:  ip_next = ip_cur;
      endcase
   end

endmodule

// File: rtl/ipr_store.sv
module ipr_store #(
   parameter int unsigned     PTR_W     = 48,
   parameter logic [PTR_W-1:0] RESET_VEC = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] ip_next,
   output logic [PTR_W-1:0] ip_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ip_q <= RESET_VEC;
      end else if (wr_en) begin
         ip_q <= ip_next;
      end
   end

   // R1
   reset_load_chk: assert property (@(posedge clk)
      rst |=> (ip_q == RESET_VEC));

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (ip_q == $past(ip_q)));

endmodule

// File: rtl/ipr_read_view.sv
module ipr_read_view
   import ipr_pkg::*;
#(
   parameter int unsigned PTR_W   = 48,
   parameter int unsigned WIDE_W  = 32,
   parameter int unsigned SHORT_W = 16,
   parameter int unsigned VIEW_W  = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PTR_W-1:0]  ip,
   input  ipr_wsize_e        wsize,
   output logic [VIEW_W-1:0] view
);

   localparam int unsigned EXT_W = VIEW_W - PTR_W;

   logic [VIEW_W-1:0] full_view;

   if (VIEW_W < PTR_W || VIEW_W <= WIDE_W) begin : g_bad_view
      $error("ipr_read_view: VIEW_W must cover the pointer");
   end

   if (EXT_W > 0) begin : g_sext
      assign full_view = {{EXT_W{ip[PTR_W-1]}}, ip};
   end else begin : g_plain
      assign full_view = ip;
   end

   always_comb begin
      unique case (wsize)
         WS_WIDE:  view = {{(VIEW_W-WIDE_W){1'b0}}, ip[WIDE_W-1:0]};
         WS_SHORT: view = {{(VIEW_W-SHORT_W){1'b0}}, ip[SHORT_W-1:0]};
         default:  view = full_view;
      endcase
   end

   // R7
   full_view_sext_chk: assert property (@(posedge clk) disable iff (rst)
      (wsize == WS_FULL || wsize == WS_IGNORE) |->
         (view[PTR_W-1:0] == ip && view[VIEW_W-1:PTR_W-1] == {(EXT_W+1){ip[PTR_W-1]}}));

   // R8
   wide_view_zext_chk: assert property (@(posedge clk) disable iff (rst)
      (wsize == WS_WIDE) |->
         (view[WIDE_W-1:0] == ip[WIDE_W-1:0] && view[VIEW_W-1:WIDE_W] == '0));

   // R9
   short_view_zext_chk: assert property (@(posedge clk) disable iff (rst)
      (wsize == WS_SHORT) |->
         (view[SHORT_W-1:0] == ip[SHORT_W-1:0] && view[VIEW_W-1:SHORT_W] == '0));

endmodule

// File: rtl/ip_reg_mode.sv
module ip_reg_mode
   import ipr_pkg::*;
#(
   parameter int unsigned      PTR_W     = 48,
   parameter int unsigned      WIDE_W    = 32,
   parameter int unsigned      SHORT_W   = 16,
   parameter int unsigned      VIEW_W    = 64,
   parameter logic [PTR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode_code,
   input  logic              cs_d,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_value,
   output logic [PTR_W-1:0]  ip_full,
   output logic [VIEW_W-1:0] ip_view
);

   ipr_wsize_e       wsize;
   logic [PTR_W-1:0] ip_next;
   logic [PTR_W-1:0] ip_q;

   ipr_size_decode u_decode (
      .mode_code (mode_code),
      .cs_d      (cs_d),
      .wsize     (wsize)
   );

   ipr_write_merge #(
      .PTR_W   (PTR_W),
      .WIDE_W  (WIDE_W),
      .SHORT_W (SHORT_W)
   ) u_merge (
      .ip_cur   (ip_q),
      .wr_value (wr_value),
      .wsize    (wsize),
      .ip_next  (ip_next)
   );

   ipr_store #(
      .PTR_W     (PTR_W),
      .RESET_VEC (RESET_VEC)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .ip_next (ip_next),
      .ip_q    (ip_q)
   );

   ipr_read_view #(
      .PTR_W   (PTR_W),
      .WIDE_W  (WIDE_W),
      .SHORT_W (SHORT_W),
      .VIEW_W  (VIEW_W)
   ) u_view (
      .clk   (clk),
      .rst   (rst),
      .ip    (ip_q),
      .wsize (wsize),
      .view  (ip_view)
   );

   assign ip_full = ip_q;

   // R3
   long_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && mode_code == MODE_LONG) |=> (ip_full == $past(wr_value)));

   // R4
   wide_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && mode_code == MODE_COMPAT && cs_d) |=>
         (ip_full[PTR_W-1:WIDE_W] == '0 && ip_full[WIDE_W-1:0] == $past(wr_value[WIDE_W-1:0])));

   // R5
   short_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && mode_code == MODE_COMPAT && !cs_d) |=>
         (ip_full[PTR_W-1:SHORT_W] == $past(ip_full[PTR_W-1:SHORT_W]) &&
          ip_full[SHORT_W-1:0] == $past(wr_value[SHORT_W-1:0])));

   // R6
   ignored_mode_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && mode_code != MODE_LONG && mode_code != MODE_COMPAT) |=>
         (ip_full == $past(ip_full)));

endmodule

// File: tb/ip_reg_mode_test.sv
module ip_reg_mode_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  mode_code;
   logic        cs_d;
   logic        wr_en;
   logic [47:0] wr_value;
   logic [47:0] ip_full;
   logic [63:0] ip_view;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [47:0] exp_ip;
   logic [47:0] q_full[$];
   logic [63:0] q_view[$];
   string       q_tag[$];
   string       q_vtag[$];

   always #5 clk = ~clk;

   ip_reg_mode uut (
      .clk       (clk),
      .rst       (rst),
      .mode_code (mode_code),
      .cs_d      (cs_d),
      .wr_en     (wr_en),
      .wr_value  (wr_value),
      .ip_full   (ip_full),
      .ip_view   (ip_view)
   );

   function automatic logic [63:0] model_view(logic [2:0] m, logic d, logic [47:0] ip);
      if (m == 3'd1 && d)  return {32'h0, ip[31:0]};
      if (m == 3'd1 && !d) return {48'h0, ip[15:0]};
      return {{16{ip[47]}}, ip};
   endfunction

   function automatic string view_tag(logic [2:0] m, logic d);
      if (m == 3'd1) return d ? "R8" : "R9";
      return "R7";
   endfunction

   // Driver: apply one cycle of stimulus, update the model, push expectation
   task automatic drive(input logic r, input logic [2:0] m, input logic d,
                        input logic we, input logic [47:0] v, input string tag);
      @(negedge clk);
      rst = r; mode_code = m; cs_d = d; wr_en = we; wr_value = v;
      @(posedge clk);
      if (r)                      exp_ip = 48'h0;
      else if (we && m == 3'd0)   exp_ip = v;
      else if (we && m == 3'd1 && d)  exp_ip = {16'h0, v[31:0]};
      else if (we && m == 3'd1 && !d) exp_ip = {exp_ip[47:16], v[15:0]};
      q_full.push_back(exp_ip);
      q_view.push_back(model_view(m, d, exp_ip));
      q_tag.push_back(tag);
      q_vtag.push_back(view_tag(m, d));
   endtask

   // Monitor: compare outputs shortly after each edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q_full.size() > 0) begin
            logic [47:0] ef;
            logic [63:0] ev;
            string t, vt;
            ef = q_full.pop_front();
            ev = q_view.pop_front();
            t  = q_tag.pop_front();
            vt = q_vtag.pop_front();
            checks++;
            if (ip_full !== ef) begin
               fails++;
               $display("FAIL %s ip_full actual=%h expected=%h", t, ip_full, ef);
            end
            checks++;
            if (ip_view !== ev) begin
               fails++;
               $display("FAIL %s ip_view actual=%h expected=%h", vt, ip_view, ev);
            end
         end
      end
   end

   initial begin
      rst = 1'b1; mode_code = 3'd0; cs_d = 1'b0; wr_en = 1'b0; wr_value = '0;
      exp_ip = '0;
      drive(1, 3'd0, 0, 0, 48'h0, "R1");
      drive(0, 3'd0, 0, 0, 48'h0, "R2");
      // R3: negative value, R7 sign extension
      drive(0, 3'd0, 0, 1, 48'h8123_4567_89AB, "R3");
      drive(0, 3'd1, 1, 0, 48'hFFFF_FFFF_FFFF, "R2");
      // R5: short write keeps bits 47:16
      drive(0, 3'd1, 0, 1, 48'hFFFF_FFFF_BEEF, "R5");
      drive(0, 3'd0, 0, 0, 48'h0, "R2");
      // R4: wide write after short write clears 47:32
      drive(0, 3'd1, 1, 1, 48'h7777_1234_5678, "R4");
      // R6: other mode codes ignore writes
      drive(0, 3'd2, 0, 1, 48'hAAAA_AAAA_AAAA, "R6");
      drive(0, 3'd3, 1, 1, 48'h5555_5555_5555, "R6");
      drive(0, 3'd4, 0, 1, 48'hFFFF_0000_FFFF, "R6");
      drive(0, 3'd7, 1, 1, 48'h1111_2222_3333, "R6");
      // positive full write, then short write preserves upper
      drive(0, 3'd0, 0, 1, 48'h7FED_CBA9_8765, "R3");
      drive(0, 3'd1, 0, 1, 48'h0000_0000_0042, "R5");
      drive(0, 3'd0, 0, 0, 48'h0, "R2");
      drive(0, 3'd1, 1, 1, 48'hCAFE_F00D_1234, "R4");
      drive(0, 3'd1, 0, 0, 48'h0, "R2");
      drive(0, 3'd0, 0, 1, 48'hFFFF_FFFF_FFFF, "R3");
      drive(1, 3'd0, 0, 1, 48'h1234_5678_9ABC, "R1");
      drive(0, 3'd5, 0, 0, 48'h0, "R2");
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule